// File: doc/BRIEF.md
# Step Attenuator Programming Sequencer

This block sits on the host side of a 6-bit digital step attenuator and turns one attenuation request into the control waveforms the attenuator expects. A client offers a word and a mode bit over a valid/ready handshake. The mode bit selects one of two paths. The serial path shifts the word out on a clock and data pair and commits it with a latch-enable pulse. The latched-parallel path drives the word onto a 6-bit bus and strobes latch enable.

Every minimum interval is a parameter in nanoseconds. Each one is rounded up to whole cycles of the system clock. The intervals covered are data setup and hold, the clock high and low times, the latch setup and width, the wait after a mode-line change, and the parallel setup, strobe and hold. When the requested mode differs from the current level of the mode line, the block changes the line first and waits out the switch time. Two commits are always separated by at least the update interval (40 µs by default, which is a 25 kHz update rate). The handshake stays closed until that interval has run.

Top module: `atten_prog_seq`

## Requirements
- R1: Out of reset, ready is high, the mode line is high (serial), latch enable is high, the serial clock and serial data are low, and the parallel bus is zero.
- R2: A request is taken only on a cycle with valid and ready both high. Ready is low on the next cycle. Valid pulses offered while ready is low start no sequence and change neither the word nor the mode that is committed.
- R3: In serial mode (mode bit 1), latch enable falls first. Six clock rising edges then carry the word, bit 5 first and bit 0 last, with data sampled on each rising edge. Latch enable is low whenever the clock is high, and its rise commits the word.
- R4: Serial data changes only while the clock is low. Data is stable for at least 10 ns before each rising edge and for at least 10 ns after it. The clock is high for at least 10 ns, and rising edges are at least 40 ns apart.
- R5: Latch enable rises no sooner than 30 ns after the last rising clock edge, which is half a 40 ns clock period plus 10 ns. It then stays high for at least 30 ns.
- R6: The mode line follows the mode bit of the accepted request and changes only at an acceptance. After a change to serial, at least 100 ns passes before the first rising clock edge. After a change to parallel, at least 100 ns passes before latch enable falls.
- R7: In parallel mode (mode bit 0), latch enable falls as the word appears on the bus. It rises at least 10 ns later, and the bus then stays unchanged for at least 10 ns. The bus reads zero whenever the mode line is high.
- R8: Successive rises of latch enable are at least the update interval apart. Ready returns high exactly the update interval, in cycles, after the commit.
- R9: While ready is high, latch enable is high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be taken |
| req_serial_i | input | 1 | 1: serial path, 0: latched parallel path |
| req_word_i | input | 6 | Attenuation word, bit 5 the largest step |
| mode_o | output | 1 | Mode line, 1 serial, 0 parallel |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| le_o | output | 1 | Latch enable |
| pword_o | output | 6 | Parallel attenuation bus |

## Verification
The hardest case to reach is the mode-switch wait. It only occurs when the requested mode differs from the current level of the mode line, and the line holds that level across any number of requests. The bench runs every word through the serial path and then every word through the parallel path, and follows that with alternating requests, so that switches in both directions are measured many times. A port monitor measures each interval in cycles from edge to edge. The bench shortens the update interval through a parameter so that the full sweep fits in the run.

// File: rtl/atten_seq_pkg.sv
package atten_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MODE,
    ST_S_LO,
    ST_S_HI,
    ST_S_LESU,
    ST_LEW,
    ST_P_SU,
    ST_P_LE,
    ST_P_HD
  } seq_state_e;

  // round a nanosecond minimum up to whole cycles, at least one
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/atten_seq_timer.sv
module atten_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/atten_seq_shift.sv
module atten_seq_shift #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  input  logic         shift_i,
  output logic         msb_o,
  output logic         last_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= d_i;
      cnt_q <= CW'(W - 1);
    end else if (shift_i) begin
      sr_q  <= sr_q << 1;
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign msb_o  = sr_q[W-1];
  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/atten_prog_seq.sv
module atten_prog_seq
  import atten_seq_pkg::*;
#(
  parameter int WORD_W        = 6,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_DSU_NS      = 10,
  parameter int T_DHD_NS      = 10,
  parameter int T_CLKHI_NS    = 20,
  parameter int T_CLKLO_NS    = 20,
  parameter int T_LESU_NS     = 10,
  parameter int T_LEW_NS      = 30,
  parameter int T_MODE_NS     = 100,
  parameter int T_PSU_NS      = 10,
  parameter int T_PLE_NS      = 10,
  parameter int T_PHD_NS      = 10,
  parameter int T_UPDATE_NS   = 40000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_serial_i,
  input  logic [WORD_W-1:0] req_word_i,
  output logic              mode_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              le_o,
  output logic [WORD_W-1:0] pword_o
);
  localparam int SLO_C  = max2(ns2cyc(T_DSU_NS, CLK_PERIOD_NS), ns2cyc(T_CLKLO_NS, CLK_PERIOD_NS));
  localparam int SHI_C  = max2(ns2cyc(T_CLKHI_NS, CLK_PERIOD_NS), ns2cyc(T_DHD_NS, CLK_PERIOD_NS));
  localparam int LESU_C = ns2cyc(T_LESU_NS, CLK_PERIOD_NS);
  localparam int LEW_C  = ns2cyc(T_LEW_NS, CLK_PERIOD_NS);
  localparam int MODE_C = ns2cyc(T_MODE_NS, CLK_PERIOD_NS);
  localparam int PSU_C  = ns2cyc(T_PSU_NS, CLK_PERIOD_NS);
  localparam int PLE_C  = ns2cyc(T_PLE_NS, CLK_PERIOD_NS);
  localparam int PHD_C  = ns2cyc(T_PHD_NS, CLK_PERIOD_NS);
  localparam int UPD_C  = ns2cyc(T_UPDATE_NS, CLK_PERIOD_NS);
  localparam int PH_MAX = max2(max2(max2(SLO_C, SHI_C), max2(LESU_C, LEW_C)),
                               max2(max2(MODE_C, PSU_C), max2(PLE_C, PHD_C)));
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int UPD_W  = $clog2(UPD_C + 1);

  seq_state_e        state_q, state_d;
  logic              mode_q, mode_d, sclk_q, sclk_d, le_q, le_d;
  logic [WORD_W-1:0] pword_q, pword_d, word_q, sel_word;
  logic              ser_q, sel_ser, accept, go;
  logic              ph_load, ph_zero, rt_load, rt_zero;
  logic [PH_W-1:0]   ph_val;
  logic              sh_load, sh_shift, sh_msb, sh_last;

  assign req_ready_o = (state_q == ST_IDLE) && rt_zero;
  assign accept      = req_valid_i && req_ready_o;
  assign sel_ser     = (state_q == ST_IDLE) ? req_serial_i : ser_q;
  assign sel_word    = (state_q == ST_IDLE) ? req_word_i : word_q;

  atten_seq_timer #(.W(PH_W)) u_phase (
    .clk_i, .rst_ni, .load_i(ph_load), .val_i(ph_val), .zero_o(ph_zero)
  );

  // counts from the commit; ready waits for it
  atten_seq_timer #(.W(UPD_W)) u_rate (
    .clk_i, .rst_ni, .load_i(rt_load), .val_i(UPD_W'(UPD_C)), .zero_o(rt_zero)
  );

  atten_seq_shift #(.W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .load_i(sh_load), .d_i(sel_word), .shift_i(sh_shift),
    .msb_o(sh_msb), .last_o(sh_last)
  );

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    sclk_d   = sclk_q;
    le_d     = le_q;
    pword_d  = pword_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    rt_load  = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    go       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (req_serial_i != mode_q) begin
          mode_d  = req_serial_i;
          if (req_serial_i) pword_d = '0;
          state_d = ST_MODE;
          ph_load = 1'b1;
          ph_val  = PH_W'(MODE_C - 1);
        end else go = 1'b1;
      end
      ST_MODE: if (ph_zero) go = 1'b1;
      ST_S_LO: if (ph_zero) begin
        sclk_d  = 1'b1;
        state_d = ST_S_HI;
        ph_load = 1'b1;
        ph_val  = PH_W'(SHI_C - 1);
      end
      ST_S_HI: if (ph_zero) begin
        sclk_d   = 1'b0;
        sh_shift = 1'b1;
        ph_load  = 1'b1;
        if (sh_last) begin
          state_d = ST_S_LESU;
          ph_val  = PH_W'(LESU_C - 1);
        end else begin
          state_d = ST_S_LO;
          ph_val  = PH_W'(SLO_C - 1);
        end
      end
      ST_S_LESU: if (ph_zero) begin
        le_d    = 1'b1;
        rt_load = 1'b1;
        state_d = ST_LEW;
        ph_load = 1'b1;
        ph_val  = PH_W'(LEW_C - 1);
      end
      ST_LEW: if (ph_zero) state_d = ST_IDLE;
      ST_P_SU: if (ph_zero) begin
        le_d    = 1'b1;
        rt_load = 1'b1;
        state_d = ST_P_LE;
        ph_load = 1'b1;
        ph_val  = PH_W'(PLE_C - 1);
      end
      ST_P_LE: if (ph_zero) begin
        state_d = ST_P_HD;
        ph_load = 1'b1;
        ph_val  = PH_W'(PHD_C - 1);
      end
      ST_P_HD: if (ph_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (go) begin
      le_d    = 1'b0;
      ph_load = 1'b1;
      if (sel_ser) begin
        sh_load = 1'b1;
        state_d = ST_S_LO;
        ph_val  = PH_W'(SLO_C - 1);
      end else begin
        pword_d = sel_word;
        state_d = ST_P_SU;
        ph_val  = PH_W'(PSU_C - 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b1;
      sclk_q  <= 1'b0;
      le_q    <= 1'b1;
      pword_q <= '0;
      word_q  <= '0;
      ser_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      sclk_q  <= sclk_d;
      le_q    <= le_d;
      pword_q <= pword_d;
      if (accept) begin
        word_q <= req_word_i;
        ser_q  <= req_serial_i;
      end
    end
  end

  assign mode_o  = mode_q;
  assign sclk_o  = sclk_q;
  assign sdata_o = sh_msb;
  assign le_o    = le_q;
  assign pword_o = pword_q;
endmodule

// File: rtl/atten_prog_seq_chk.sv
module atten_prog_seq_chk #(
  parameter int GAP_C  = 2,
  parameter int WORD_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              mode_o,
  input logic              sclk_o,
  input logic              sdata_o,
  input logic              le_o,
  input logic [WORD_W-1:0] pword_o
);
  localparam int GW = $clog2(GAP_C + 1) + 1;

  logic          le_d;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_d  <= 1'b1;
      gap_q <= GW'(GAP_C);
    end else begin
      le_d <= le_o;
      if (le_o && !le_d)          gap_q <= GW'(1);
      else if (gap_q < GW'(GAP_C)) gap_q <= gap_q + 1'b1;
    end
  end

  p_idle_le_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (le_o && !sclk_o));
  p_ready_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  p_data_clk_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> !sclk_o);
  p_clk_le_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !le_o);
  p_bus_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o |-> (pword_o == '0));
  p_bus_change_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pword_o) |-> (!le_o || mode_o));
  p_mode_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> $past(req_valid_i && req_ready_o));
  p_commit_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_o && !le_d) |-> (gap_q >= GW'(GAP_C)));
endmodule

bind atten_prog_seq atten_prog_seq_chk #(.GAP_C(UPD_C), .WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .mode_o(mode_o), .sclk_o(sclk_o), .sdata_o(sdata_o), .le_o(le_o), .pword_o(pword_o)
);

// File: tb/atten_prog_seq_bench.sv
module atten_prog_seq_bench;
  localparam int P   = 4;
  localparam int UPD = 800;

  function automatic int cyc(input int ns);
    return (ns + P - 1) / P;
  endfunction

  localparam int SU_C   = cyc(10);
  localparam int HD_C   = cyc(10);
  localparam int HI_C   = cyc(10);
  localparam int PER_C  = cyc(40);
  localparam int LESU_C = cyc(20 + 10);
  localparam int LEW_C  = cyc(30);
  localparam int MODE_C = cyc(100);
  localparam int PSU_C  = cyc(10);
  localparam int PHD_C  = cyc(10);
  localparam int UPD_C  = cyc(UPD);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_serial = 1'b1;
  logic [5:0] req_word = '0;
  logic       ready, mode, sclk, sdata, le;
  logic [5:0] pword;

  int checks = 0, failures = 0;
  int commits = 0;
  logic       exp_mode = 1'b1;
  logic [5:0] exp_word = '0;

  always #(P/2) clk = ~clk;

  atten_prog_seq #(.CLK_PERIOD_NS(P), .T_UPDATE_NS(UPD)) u_atten_prog_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
    .req_serial_i(req_serial), .req_word_i(req_word), .mode_o(mode),
    .sclk_o(sclk), .sdata_o(sdata), .le_o(le), .pword_o(pword)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // port monitor: counters hold edge distances
  int s_rise = 100000, s_dchg = 100000, s_mode = 100000, s_ler = 100000, s_pchg = 100000;
  int nrise = 0;
  bit pend_mode = 0;
  logic [5:0] sr = '0;
  logic p_sclk = 0, p_sdata = 0, p_le = 1, p_mode = 1, p_ready = 1;
  logic [5:0] p_pword = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      s_rise++; s_dchg++; s_mode++; s_ler++; s_pchg++;
      if (mode != p_mode) begin s_mode = 0; pend_mode = 1; end
      if (sdata != p_sdata) begin
        chk(!sclk, "R4 data moved with clock high", int'(sclk), 0);
        chk(s_rise >= HD_C, "R4 data hold", s_rise, HD_C);
        s_dchg = 0;
      end
      if (sclk && !p_sclk) begin
        chk(s_rise >= PER_C, "R4 clock period", s_rise, PER_C);
        chk(s_dchg >= SU_C, "R4 data setup", s_dchg, SU_C);
        chk(!le, "R3 latch low while shifting", int'(le), 0);
        if (pend_mode) begin
          chk(s_mode >= MODE_C, "R6 switch to serial wait", s_mode, MODE_C);
          pend_mode = 0;
        end
        sr = {sr[4:0], sdata};
        nrise++;
        s_rise = 0;
      end
      if (!sclk && p_sclk) chk(s_rise >= HI_C, "R4 clock high width", s_rise, HI_C);
      if (pword != p_pword) begin
        chk(s_ler >= PHD_C, "R7 bus hold", s_ler, PHD_C);
        s_pchg = 0;
      end
      if (!le && p_le) begin
        chk(s_ler >= LEW_C, "R5 latch high width", s_ler, LEW_C);
        if (!mode && pend_mode) begin
          chk(s_mode >= MODE_C, "R6 switch to parallel wait", s_mode, MODE_C);
          pend_mode = 0;
        end
        nrise = 0;
      end
      if (le && !p_le) begin
        chk(s_ler >= UPD_C, "R8 commit spacing", s_ler, UPD_C);
        chk(mode == exp_mode, "R6 mode line", int'(mode), int'(exp_mode));
        if (mode) begin
          chk(s_rise >= LESU_C, "R5 latch setup", s_rise, LESU_C);
          chk(nrise == 6, "R3 edge count", nrise, 6);
          chk(sr == exp_word, "R3 serial word", int'(sr), int'(exp_word));
        end else begin
          chk(s_pchg >= PSU_C, "R7 bus setup", s_pchg, PSU_C);
          chk(nrise == 0, "R7 no clock in parallel", nrise, 0);
          chk(pword == exp_word, "R7 parallel word", int'(pword), int'(exp_word));
        end
        commits++;
        s_ler = 0;
      end
      if (ready && !p_ready)
        chk(s_ler == UPD_C, "R8 ready return", s_ler, UPD_C);
      if (ready) chk(le && !sclk, "R9 idle levels", int'({le, sclk}), 2);
      if (mode) chk(pword == '0, "R7 bus zero in serial", int'(pword), 0);
    end
    p_sclk = sclk; p_sdata = sdata; p_le = le; p_mode = mode; p_ready = ready; p_pword = pword;
  end

  task automatic do_req(input logic ser, input logic [5:0] w, input int junk);
    int c0;
    while (!ready) @(negedge clk);
    exp_mode = ser; exp_word = w; c0 = commits;
    req_serial = ser; req_word = w; req_valid = 1'b1;
    @(negedge clk);
    chk(!ready, "R2 ready low after accept", int'(ready), 0);
    // R2: offers while busy must be ignored
    req_serial = ~ser; req_word = ~w;
    req_valid = (junk != 0);
    for (int i = 0; i < junk; i++) @(negedge clk);
    req_valid = 1'b0;
    while (!ready) @(negedge clk);
    chk(commits == c0 + 1, "R2 one commit per request", commits, c0 + 1);
    chk(mode == ser, "R2 R6 mode after request", int'(mode), int'(ser));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready && mode && le && !sclk && !sdata && pword == '0, "R1 reset levels",
        int'({ready, mode, le, sclk, sdata}), 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && mode && le, "R1 after release", int'({ready, mode, le}), 3'b111);
    for (int w = 0; w < 64; w++) do_req(1'b1, 6'(w), 0);
    for (int w = 0; w < 64; w++) do_req(1'b0, 6'(63 - w), 0);
    for (int i = 0; i < 8; i++) do_req(i[0], 6'(i * 9 + 5), 0);
    do_req(1'b1, 6'h2a, 60);
    do_req(1'b0, 6'h15, 60);
    do_req(1'b0, 6'h3f, 3);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule